// File: doc/BRIEF.md
# Dual-Channel System Timer

A two-channel timer that sits on a simple register bus with separate read and write strobes and a byte address. Channel 1 is a one-shot event timer. It counts up from zero, and when its count reaches a programmed compare value it raises a flag. The flag drives the interrupt output unless a mask bit blocks it. After the match the count stays where it is, so one arming gives one event. Channel 2 is a free-running timestamp counter that is two data words wide. Software reads the low word first and then the high buffer, and the two reads together give one coherent value.

Each channel has its own prescaler code n, which divides the input clock by 4^n. A channel is started through a write-one-to-set register and stopped through a write-one-to-clear register. Each counter is returned to zero through a separate counter-clear register. The typical flow for an event is:

1. Stop channel 1.
2. Clear its count and its flag.
3. Write the compare value.
4. Start channel 1.
5. Wait for the interrupt.

Top module: `dual_timer`

## Requirements
- R1: After reset:
  - both prescale codes, both enables, both counters and the flag read zero;
  - the mask reads one;
  - `irq_o` is low.
- R2: A write to the enable-set register (byte 0x34) starts channel 1 for each 1 in bit 0 and channel 2 for each 1 in bit 1. A write to the enable-clear register (0x38) stops the channel in the same way. Zero bits leave the enable unchanged. Reading 0x34 returns the two enable bits in bits [1:0].
- R3: The prescale register (0x00) holds the channel-1 code in bits [1:0] and the channel-2 code in bits [3:2]. It reads back as written. Code n advances the selected counter once every 4^n input clocks.
- R4: With channel 1 idle, its count cleared and compare value C (register 0x14, 1 <= C <= 2^DATA_W-1), the flag (bit 0 of 0x0C) sets exactly C*4^n clocks after the clock edge that applies the enable-set write.
- R5: Once the channel-1 count equals the compare value, the count holds (it is read at 0x18). After the flag has been cleared, it does not set again until the count is cleared.
- R6: Writing 0 to flag bit 0 clears the flag. Writing 1 to it has no effect.
- R7: `irq_o` is high exactly when the flag is 1 and mask bit 0 (register 0x10) is 0.
- R8: A write to 0x08 returns the channel-1 count to zero for each 1 in bit 0, and the whole channel-2 count to zero for each 1 in bit 1. Register 0x08 reads as zero.
- R9: The channel-2 low word (0x20) counts continuously while the channel is enabled. It wraps from all ones to zero and carries into the upper word.
- R10: A read of 0x20 copies the upper word into the high buffer (0x24) at the same instant the low word is returned. The buffer then keeps that value until the next read of 0x20.
- R11: Writes to the counter registers 0x18 and 0x20 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single timer and bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_rd | input | 1 | Read strobe, one clock per read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from the address |
| irq_o | output | 1 | Channel-1 event interrupt, flag and not mask |

## Verification
A wrong prescaler or counter state appears at the ports as an interrupt that arrives a measurable number of clocks early or late. The bench therefore times the interrupt against C*4^n across every code and a range of compare values, so an off-by-one error shows within a single arming. A lost hold-after-match or a spurious re-trigger shows as the flag setting again during a long idle window. A wrong carry or a wrong buffer latch shows as an incoherent low and high pair when the low word is read at all ones, in a reduced-width configuration where the wrap occurs within a few hundred clocks.

// File: rtl/dtm_pkg.sv
package dtm_pkg;
    // Byte offsets of the registers
    localparam int OFF_PRESCALE = 'h00;
    localparam int OFF_CLEAR    = 'h08;
    localparam int OFF_FLAG     = 'h0C;
    localparam int OFF_MASK     = 'h10;
    localparam int OFF_CMP      = 'h14;
    localparam int OFF_CNT1     = 'h18;
    localparam int OFF_LO       = 'h20;
    localparam int OFF_HIBUF    = 'h24;
    localparam int OFF_ENSET    = 'h34;
    localparam int OFF_ENCLR    = 'h38;

    localparam int NUM_CH = 2;
    localparam int CODE_W = 2;
    // Prescaler counter width covers the largest divider 4^(2^CODE_W-1)
    localparam int PRE_CW = 2 * ((1 << CODE_W) - 1);

    typedef logic [CODE_W-1:0] pcode_t;

    // Terminal count of the prescaler for a given code (divider minus one)
    function automatic logic [PRE_CW-1:0] pre_limit(input pcode_t code);
        return PRE_CW'((1 << (2 * int'(code))) - 1);
    endfunction
endpackage

// File: rtl/dtm_prescaler.sv
module dtm_prescaler
    import dtm_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   run_i,
    input  pcode_t code_i,
    output logic   tick_o
);
    typedef struct packed {
        logic [PRE_CW-1:0] cnt;
    } pre_st_t;

    pre_st_t s_d, s_q;
    logic    at_lim;

    always_comb begin
        s_d    = s_q;
        at_lim = (s_q.cnt >= pre_limit(code_i));
        tick_o = run_i && at_lim;
        if (!run_i || at_lim) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R3: a tick always restarts the division period
    a_r3_tick_restart: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (s_q.cnt == '0));
endmodule

// File: rtl/dtm_event_chan.sv
module dtm_event_chan #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         clr_i,
    input  logic         cmp_we_i,
    input  logic [W-1:0] cmp_wdata_i,
    input  logic         flag_we_i,
    input  logic         flag_wbit_i,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] cmp_o,
    output logic         flag_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] cmp;
        logic         flag;
    } ev_st_t;

    ev_st_t s_d, s_q;
    logic   hit;
    logic   matched;

    always_comb begin
        s_d     = s_q;
        hit     = 1'b0;
        matched = (s_q.cnt == s_q.cmp);
        if (cmp_we_i) begin
            s_d.cmp = cmp_wdata_i;
        end
        if (clr_i) begin
            s_d.cnt = '0;
        end else if (tick_i && !matched) begin
            s_d.cnt = s_q.cnt + 1'b1;
            hit     = (s_d.cnt == s_q.cmp);
        end
        // hardware set wins over a software clear in the same cycle
        if (hit) begin
            s_d.flag = 1'b1;
        end else if (flag_we_i && !flag_wbit_i) begin
            s_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o  = s_q.cnt;
    assign cmp_o  = s_q.cmp;
    assign flag_o = s_q.flag;

    // R4: each tick below the compare value adds exactly one
    a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !clr_i && (cnt_o != cmp_o)) |=> (cnt_o == $past(cnt_o) + 1'b1));
    // R4: the flag only rises when the count sits on the compare value
    a_r4_flag_at_match: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flag_o) && !$past(cmp_we_i)) |-> (cnt_o == cmp_o));
    // R5: a matched count holds until cleared or the compare value moves
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_o == cmp_o) && !clr_i && !cmp_we_i) |=> $stable(cnt_o));
endmodule

// File: rtl/dtm_stamp_chan.sv
module dtm_stamp_chan #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         clr_i,
    input  logic         lo_rd_i,
    output logic [W-1:0] lo_o,
    output logic [W-1:0] hibuf_o
);
    typedef struct packed {
        logic [W-1:0] lo;
        logic [W-1:0] hi;
        logic [W-1:0] hbuf;
    } ts_st_t;

    ts_st_t s_d, s_q;
    logic   lo_full;

    always_comb begin
        s_d     = s_q;
        lo_full = &s_q.lo;
        // the buffer takes the upper word of the same cycle the low word is read
        if (lo_rd_i) begin
            s_d.hbuf = s_q.hi;
        end
        if (clr_i) begin
            s_d.lo = '0;
            s_d.hi = '0;
        end else if (tick_i) begin
            s_d.lo = s_q.lo + 1'b1;
            if (lo_full) begin
                s_d.hi = s_q.hi + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign lo_o    = s_q.lo;
    assign hibuf_o = s_q.hbuf;

    // R9: the low word wraps to zero and carries into the upper word
    a_r9_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !clr_i && (&lo_o)) |=> ((lo_o == '0) && (s_q.hi == $past(s_q.hi) + 1'b1)));
    // R10: the buffer only changes on a low-word read
    a_r10_buf_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !lo_rd_i |=> $stable(hibuf_o));
    // R8: clearing empties the whole count
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> ((lo_o == '0) && (s_q.hi == '0)));
endmodule

// File: rtl/dual_timer.sv
module dual_timer
    import dtm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    localparam int PRE_BITS = NUM_CH * CODE_W;

    typedef struct packed {
        logic [NUM_CH-1:0][CODE_W-1:0] code;
        logic [NUM_CH-1:0]             en;
        logic                          mask;
    } top_st_t;

    top_st_t s_d, s_q;

    logic              we_pre, we_clr, we_flag, we_mask, we_cmp, we_set, we_unset, rd_lo;
    logic [NUM_CH-1:0] tick;
    logic [DATA_W-1:0] cnt1, cmp1, lo2, hbuf2;
    logic              flag1;

    function automatic logic at(input logic [ADDR_W-1:0] a, input int off);
        return a == ADDR_W'(off);
    endfunction

    always_comb begin
        we_pre   = bus_wr && at(bus_addr, OFF_PRESCALE);
        we_clr   = bus_wr && at(bus_addr, OFF_CLEAR);
        we_flag  = bus_wr && at(bus_addr, OFF_FLAG);
        we_mask  = bus_wr && at(bus_addr, OFF_MASK);
        we_cmp   = bus_wr && at(bus_addr, OFF_CMP);
        we_set   = bus_wr && at(bus_addr, OFF_ENSET);
        we_unset = bus_wr && at(bus_addr, OFF_ENCLR);
        rd_lo    = bus_rd && at(bus_addr, OFF_LO);
    end

    always_comb begin
        s_d = s_q;
        if (we_pre) begin
            s_d.code = bus_wdata[PRE_BITS-1:0];
        end
        if (we_set) begin
            s_d.en = s_q.en | bus_wdata[NUM_CH-1:0];
        end
        if (we_unset) begin
            s_d.en = s_q.en & ~bus_wdata[NUM_CH-1:0];
        end
        if (we_mask) begin
            s_d.mask = bus_wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{code: '0, en: '0, mask: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_pre
        dtm_prescaler u_pre (
            .clk    (clk),
            .rst_n  (rst_n),
            .run_i  (s_q.en[g]),
            .code_i (s_q.code[g]),
            .tick_o (tick[g])
        );
    end

    dtm_event_chan #(.W(DATA_W)) u_ev (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick[0]),
        .clr_i       (we_clr && bus_wdata[0]),
        .cmp_we_i    (we_cmp),
        .cmp_wdata_i (bus_wdata),
        .flag_we_i   (we_flag),
        .flag_wbit_i (bus_wdata[0]),
        .cnt_o       (cnt1),
        .cmp_o       (cmp1),
        .flag_o      (flag1)
    );

    dtm_stamp_chan #(.W(DATA_W)) u_ts (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick[1]),
        .clr_i   (we_clr && bus_wdata[1]),
        .lo_rd_i (rd_lo),
        .lo_o    (lo2),
        .hibuf_o (hbuf2)
    );

    always_comb begin
        bus_rdata = '0;
        if (at(bus_addr, OFF_PRESCALE)) begin
            bus_rdata = DATA_W'(s_q.code);
        end else if (at(bus_addr, OFF_FLAG)) begin
            bus_rdata = DATA_W'(flag1);
        end else if (at(bus_addr, OFF_MASK)) begin
            bus_rdata = DATA_W'(s_q.mask);
        end else if (at(bus_addr, OFF_CMP)) begin
            bus_rdata = cmp1;
        end else if (at(bus_addr, OFF_CNT1)) begin
            bus_rdata = cnt1;
        end else if (at(bus_addr, OFF_LO)) begin
            bus_rdata = lo2;
        end else if (at(bus_addr, OFF_HIBUF)) begin
            bus_rdata = hbuf2;
        end else if (at(bus_addr, OFF_ENSET)) begin
            bus_rdata = DATA_W'(s_q.en);
        end
    end

    assign irq_o = flag1 && !s_q.mask;

    // R2: channel 1 starts only on a set write carrying a one in bit 0
    a_r2_start_needs_set: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.en[0]) |-> $past(we_set && bus_wdata[0]));
    // R2: channel 1 stops only on a clear write carrying a one in bit 0
    a_r2_stop_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.en[0]) |-> $past(we_unset && bus_wdata[0]));
endmodule

// File: tb/dual_timer_test.sv
`timescale 1ns/1ps
module dual_timer_test;
    localparam int DW = 8;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dual_timer #(.DATA_W(DW), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = DW'(d);
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = AW'(a);
        #1 v = int'(bus_rdata);
        @(posedge clk);
        #1 bus_rd = 1'b0;
    endtask

    // clocks from the enable edge until irq is seen high
    task automatic time_irq(output int k);
        k = 0;
        forever begin
            @(negedge clk);
            if (irq_o) break;
            k++;
            if (k > 5000) break;
        end
    endtask

    task automatic arm1(input int code, input int c);
        wr('h38, 1);
        wr('h08, 1);
        wr('h0C, 0);
        wr('h00, code);
        wr('h14, c);
        wr('h34, 1);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int v, k;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd('h00, v); chk("R1 prescale", v, 0);
        rd('h34, v); chk("R1 enables", v, 0);
        rd('h18, v); chk("R1 cnt1", v, 0);
        rd('h20, v); chk("R1 lo", v, 0);
        rd('h0C, v); chk("R1 flag", v, 0);
        rd('h10, v); chk("R1 mask", v, 1);
        chk("R1 irq", int'(irq_o), 0);

        // R2 set / clear enables, zeros ignored
        wr('h34, 0); rd('h34, v); chk("R2 set zero", v, 0);
        wr('h34, 3); rd('h34, v); chk("R2 set both", v, 3);
        wr('h38, 0); rd('h38 - 4, v); rd('h34, v); chk("R2 clear zero", v, 3);
        wr('h38, 2); rd('h34, v); chk("R2 clear ch2", v, 1);
        wr('h38, 1); rd('h34, v); chk("R2 clear ch1", v, 0);

        // R3 prescale readback
        wr('h00, 9); rd('h00, v); chk("R3 readback", v, 9);

        wr('h08, 3);
        wr('h10, 0);

        // R4 / R3 sweep over codes and compare values
        for (int code = 0; code < 3; code++) begin
            for (int c = 1; c <= 8; c++) begin
                arm1(code, c);
                time_irq(k);
                chk($sformatf("R4 code%0d cmp%0d", code, c), k, c << (2 * code));
            end
        end

        // R5 hold after match (code 2, compare 8)
        rd('h18, v); chk("R5 held", v, 8);
        repeat (50) @(negedge clk);
        rd('h18, v); chk("R5 still held", v, 8);
        // R6 writing one leaves the flag, writing zero clears it
        wr('h0C, 1); rd('h0C, v); chk("R6 write one", v, 1);
        wr('h0C, 0); rd('h0C, v); chk("R6 write zero", v, 0);
        repeat (200) @(negedge clk);
        rd('h0C, v); chk("R5 no retrigger", v, 0);
        chk("R5 irq quiet", int'(irq_o), 0);

        // R7 mask gating
        arm1(0, 4);
        time_irq(k);
        chk("R7 irq unmasked", int'(irq_o), 1);
        wr('h10, 1);
        chk("R7 irq masked", int'(irq_o), 0);
        rd('h0C, v); chk("R7 flag under mask", v, 1);
        wr('h10, 0);
        chk("R7 irq unmasked again", int'(irq_o), 1);

        // R11 counter write ignored
        wr('h18, 'h55); rd('h18, v); chk("R11 cnt1 write", v, 4);

        // R8 clear channel 1
        wr('h38, 1);
        wr('h08, 1); rd('h18, v); chk("R8 cnt1 cleared", v, 0);
        rd('h08, v); chk("R8 reads zero", v, 0);

        // R4 largest compare
        arm1(0, 255);
        time_irq(k);
        chk("R4 max compare", k, 255);
        wr('h38, 1);

        // R9 / R10 wrap and coherent buffer on channel 2
        wr('h38, 2); wr('h08, 2); wr('h00, 0); wr('h34, 2);
        repeat (255) @(negedge clk);
        rd('h20, v); chk("R9 lo at all ones", v, 255);
        rd('h24, v); chk("R10 buffer before carry", v, 0);
        repeat (10) @(negedge clk);
        rd('h24, v); chk("R10 buffer holds", v, 0);
        wr('h20, 'hAA);
        rd('h20, v); chk("R9 lo after wrap", v, 13);
        chk("R11 lo write ignored", v, 13);
        rd('h24, v); chk("R9 carry into upper", v, 1);

        // R3 channel-2 prescale sweep
        for (int code = 0; code < 3; code++) begin
            wr('h38, 2); wr('h08, 2); wr('h00, code << 2); wr('h34, 2);
            repeat (40) @(negedge clk);
            rd('h20, v);
            chk($sformatf("R3 ch2 code%0d", code), v, 40 >> (2 * code));
        end

        // R8 clear channel 2
        wr('h38, 2);
        wr('h08, 2);
        rd('h20, v); chk("R8 lo cleared", v, 0);
        rd('h24, v); chk("R8 upper cleared", v, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule